// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Format Adaptation

This block holds audio samples in two 32-bit FIFOs that sit between a register bus and a serial audio engine. The receive FIFO is filled by the engine and drained by bus reads. The transmit FIFO is filled by bus writes and drained by the engine. Inside both FIFOs every sample is kept MSB-aligned, and any unused low bits are zero.

Format adaptation happens at the bus edge only. A bus word bound for the transmit FIFO can be taken as it is, or it can be treated as right-justified and moved to the top of the word. A receive word read out by the bus can be returned in one of four layouts: as stored, right-justified with sign extension, truncated to 16 bits in the upper half, or truncated to 16 bits in the lower half with sign extension. Each FIFO drives a request flag against a threshold that software programs. The receive threshold is the level field plus one. The transmit threshold compares free space with the level field directly. A one-cycle flush strobe empties either FIFO. Sample width is a runtime input from 8 to 32 bits, and values outside that range are clamped into it. Both depths must be powers of two.

Top module: `audio_sample_fifo`

## Requirements
- R1: Each FIFO returns words in the order they were accepted, and its count output gives the number of words held.
- R2: Receive output mode 0 returns the stored word unchanged.
- R3: Receive output mode 1 returns the stored word arithmetically shifted right by 32 minus the sample width, so the sample is right-justified and the upper bits copy bit 31.
- R4: Receive output mode 2 returns stored bits 31:16 in bits 31:16, with bits 15:0 equal to zero.
- R5: Receive output mode 3 returns stored bits 31:16 in bits 15:0, with bits 31:16 all equal to stored bit 31.
- R6: Transmit input mode 0 (mode input low) stores the bus word unchanged.
- R7: Transmit input mode 1 (mode input high) stores the bus word shifted left by 32 minus the sample width, with zeros shifted in.
- R8: The receive request is high exactly when the receive count is at least the receive level plus one.
- R9: The transmit request is high exactly when the transmit depth minus the transmit count is at least the transmit level.
- R10: A flush strobe empties its FIFO at the next clock edge, even when a push or write arrives in the same cycle.
- R11: A push to a full receive FIFO, a bus read from an empty receive FIFO, and an engine pop from an empty transmit FIFO each leave the count unchanged.
- R12: A receive push and a bus read accepted in the same cycle leave the receive count unchanged and advance the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr_en | input | 1 | Bus write into transmit FIFO |
| bus_wdata | input | 32 | Bus write data |
| bus_rd_en | input | 1 | Bus read, pops receive FIFO |
| bus_rdata | output | 32 | Formatted receive head word |
| eng_rx_push | input | 1 | Engine pushes a receive sample |
| eng_rx_data | input | 32 | MSB-aligned receive sample |
| eng_tx_pop | input | 1 | Engine pops a transmit sample |
| eng_tx_data | output | 32 | Transmit head word |
| sample_bits | input | 6 | Sample width, 8 to 32 |
| rx_out_mode | input | 2 | Receive readout layout, 0 to 3 |
| tx_in_mode | input | 1 | Transmit input alignment |
| rx_level | input | 6 | Receive request level |
| tx_level | input | 7 | Transmit request level |
| rx_flush | input | 1 | Empty receive FIFO strobe |
| tx_flush | input | 1 | Empty transmit FIFO strobe |
| rx_req | output | 1 | Receive request |
| tx_req | output | 1 | Transmit request |
| rx_count | output | RX_CW | Receive words held |
| tx_count | output | TX_CW | Transmit words held |

## Verification
Two actions collide on the receive side. A flush strobe can arrive together with an engine push, and a push can arrive together with a bus read. The bench raises each pair in one driven cycle. For the flush case it expects a count of zero afterwards, which shows the flush took priority. For the push-and-read case it expects the count to stay the same and the head to move to the newly pushed word. The transmit side is judged the same way, using a flush that arrives together with a bus write.

// File: rtl/audio_sample_fifo.sv
`timescale 1ns/1ps
module audio_sample_fifo #(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 128,
  parameter int RX_CW = $clog2(RX_DEPTH + 1),
  parameter int TX_CW = $clog2(TX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr_en,
  input  logic [31:0]      bus_wdata,
  input  logic             bus_rd_en,
  output logic [31:0]      bus_rdata,
  input  logic             eng_rx_push,
  input  logic [31:0]      eng_rx_data,
  input  logic             eng_tx_pop,
  output logic [31:0]      eng_tx_data,
  input  logic [5:0]       sample_bits,
  input  logic [1:0]       rx_out_mode,
  input  logic             tx_in_mode,
  input  logic [5:0]       rx_level,
  input  logic [6:0]       tx_level,
  input  logic             rx_flush,
  input  logic             tx_flush,
  output logic             rx_req,
  output logic             tx_req,
  output logic [RX_CW-1:0] rx_count,
  output logic [TX_CW-1:0] tx_count
);
  localparam int RX_AW = $clog2(RX_DEPTH);
  localparam int TX_AW = $clog2(TX_DEPTH);

  logic [31:0] rx_mem [RX_DEPTH];
  logic [31:0] tx_mem [TX_DEPTH];
  logic [RX_AW-1:0] rx_wp, rx_rp;
  logic [TX_AW-1:0] tx_wp, tx_rp;

  logic [5:0] width_c, shamt;
  assign width_c = (sample_bits < 6'd8) ? 6'd8 : (sample_bits > 6'd32) ? 6'd32 : sample_bits;
  assign shamt   = 6'd32 - width_c;

  logic rx_full, rx_in, rx_out, tx_full, tx_in, tx_out;
  assign rx_full = rx_count == RX_CW'(RX_DEPTH);
  assign tx_full = tx_count == TX_CW'(TX_DEPTH);
  assign rx_in   = eng_rx_push && !rx_full;
  assign rx_out  = bus_rd_en && (rx_count != '0);
  assign tx_in   = bus_wr_en && !tx_full;
  assign tx_out  = eng_tx_pop && (tx_count != '0);

  logic [31:0] tx_word, rx_head;
  assign tx_word = tx_in_mode ? (bus_wdata << shamt) : bus_wdata;
  assign rx_head = rx_mem[rx_rp];

  always_comb begin
    case (rx_out_mode)
      2'd0: bus_rdata = rx_head;
      2'd1: bus_rdata = $unsigned($signed(rx_head) >>> shamt);
      2'd2: bus_rdata = {rx_head[31:16], 16'h0000};
      default: bus_rdata = {{16{rx_head[31]}}, rx_head[31:16]};
    endcase
  end

  assign eng_tx_data = tx_mem[tx_rp];

  always_ff @(posedge clk) begin
    if (rx_in && !rx_flush) rx_mem[rx_wp] <= eng_rx_data;
    if (tx_in && !tx_flush) tx_mem[tx_wp] <= tx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_count <= '0;
    end else if (rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_count <= '0;
    end else begin
      if (rx_in)  rx_wp <= rx_wp + 1'b1;
      if (rx_out) rx_rp <= rx_rp + 1'b1;
      rx_count <= rx_count + RX_CW'(rx_in) - RX_CW'(rx_out);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_count <= '0;
    end else if (tx_flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_count <= '0;
    end else begin
      if (tx_in)  tx_wp <= tx_wp + 1'b1;
      if (tx_out) tx_rp <= tx_rp + 1'b1;
      tx_count <= tx_count + TX_CW'(tx_in) - TX_CW'(tx_out);
    end
  end

  assign rx_req = 32'(rx_count) >= 32'(rx_level) + 32'd1;
  assign tx_req = 32'(TX_DEPTH) - 32'(tx_count) >= 32'(tx_level);

  assert_rx_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> rx_count == '0);
  assert_tx_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> tx_count == '0);
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && eng_rx_push && !bus_rd_en && !rx_flush) |=> $stable(rx_count));
  assert_tx_empty_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0 && eng_tx_pop && !bus_wr_en && !tx_flush) |=> tx_count == '0);
  assert_push_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_push && bus_rd_en && rx_count != '0 && !rx_full && !rx_flush) |=> $stable(rx_count));
  assert_mode2_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_mode == 2'd2) |-> bus_rdata[15:0] == 16'h0000);
endmodule

// File: tb/audio_sample_fifo_tb_top.sv
`timescale 1ns/1ps
module audio_sample_fifo_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr_en = 0, bus_rd_en = 0, eng_rx_push = 0, eng_tx_pop = 0;
  logic [31:0] bus_wdata = '0, eng_rx_data = '0;
  logic [31:0] bus_rdata, eng_tx_data;
  logic [5:0] sample_bits = 6'd24, rx_level = '0;
  logic [1:0] rx_out_mode = '0;
  logic tx_in_mode = 0, rx_flush = 0, tx_flush = 0;
  logic [6:0] tx_level = '0;
  logic rx_req, tx_req;
  logic [6:0] rx_count;
  logic [7:0] tx_count;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  audio_sample_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
    .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .sample_bits(sample_bits), .rx_out_mode(rx_out_mode), .tx_in_mode(tx_in_mode),
    .rx_level(rx_level), .tx_level(tx_level), .rx_flush(rx_flush), .tx_flush(tx_flush),
    .rx_req(rx_req), .tx_req(tx_req), .rx_count(rx_count), .tx_count(tx_count));

  // {dir[79], mode[77:76], width[69:64], input[63:32], expected[31:0]}
  localparam logic [79:0] VEC [13] = '{
    {1'b0,1'b0,2'd0,6'd0,6'd20,32'hABCDE000,32'hABCDE000},
    {1'b0,1'b0,2'd1,6'd0,6'd20,32'hABCDE000,32'hFFFABCDE},
    {1'b0,1'b0,2'd1,6'd0,6'd16,32'h12340000,32'h00001234},
    {1'b0,1'b0,2'd1,6'd0,6'd32,32'h80000001,32'h80000001},
    {1'b0,1'b0,2'd1,6'd0,6'd8, 32'h80000000,32'hFFFFFF80},
    {1'b0,1'b0,2'd2,6'd0,6'd24,32'h89ABCD00,32'h89AB0000},
    {1'b0,1'b0,2'd3,6'd0,6'd24,32'h89ABCD00,32'hFFFF89AB},
    {1'b0,1'b0,2'd3,6'd0,6'd24,32'h7FFF0000,32'h00007FFF},
    {1'b1,1'b0,2'd0,6'd0,6'd20,32'h12345678,32'h12345678},
    {1'b1,1'b0,2'd1,6'd0,6'd20,32'h000ABCDE,32'hABCDE000},
    {1'b1,1'b0,2'd1,6'd0,6'd8, 32'h000000A5,32'hA5000000},
    {1'b1,1'b0,2'd1,6'd0,6'd24,32'hFF123456,32'h12345600},
    {1'b1,1'b0,2'd1,6'd0,6'd32,32'hDEADBEEF,32'hDEADBEEF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_rx(input logic [31:0] w);
    eng_rx_push = 1; eng_rx_data = w;
    @(negedge clk); eng_rx_push = 0;
  endtask

  task automatic read_rx();
    bus_rd_en = 1; @(negedge clk); bus_rd_en = 0;
  endtask

  task automatic write_tx(input logic [31:0] w);
    bus_wr_en = 1; bus_wdata = w;
    @(negedge clk); bus_wr_en = 0;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset rx_count", 32'(rx_count), 0);
    chk("R1 reset tx_count", 32'(tx_count), 0);
    chk("R8 reset rx_req", 32'(rx_req), 0);
    chk("R9 reset tx_req", 32'(tx_req), 1);

    for (int i = 0; i < 13; i++) begin
      string tag;
      sample_bits = VEC[i][69:64];
      if (!VEC[i][79]) begin
        rx_out_mode = VEC[i][77:76];
        case (VEC[i][77:76])
          2'd0: tag = "R2 rx mode0";
          2'd1: tag = "R3 rx mode1";
          2'd2: tag = "R4 rx mode2";
          default: tag = "R5 rx mode3";
        endcase
        push_rx(VEC[i][63:32]);
        chk(tag, bus_rdata, VEC[i][31:0]);
        read_rx();
      end else begin
        tx_in_mode = VEC[i][76];
        tag = VEC[i][76] ? "R7 tx mode1" : "R6 tx mode0";
        write_tx(VEC[i][63:32]);
        chk(tag, eng_tx_data, VEC[i][31:0]);
        eng_tx_pop = 1; @(negedge clk); eng_tx_pop = 0;
      end
    end
    rx_out_mode = 2'd0; tx_in_mode = 0;

    for (int i = 0; i < 64; i++) push_rx(32'(i) << 8);
    chk("R1 rx full count", 32'(rx_count), 64);
    push_rx(32'hFFFFFFFF);
    chk("R11 push to full ignored", 32'(rx_count), 64);
    for (int i = 0; i < 64; i++) begin
      if (bus_rdata !== (32'(i) << 8)) chk("R1 rx order", bus_rdata, 32'(i) << 8);
      read_rx();
    end
    chk("R1 rx order all", 32'(rx_count), 0);
    read_rx();
    chk("R11 read empty ignored", 32'(rx_count), 0);
    eng_tx_pop = 1; @(negedge clk); eng_tx_pop = 0;
    chk("R11 tx pop empty ignored", 32'(tx_count), 0);

    rx_level = 6'd3;
    for (int i = 0; i < 3; i++) push_rx(32'h11110000);
    chk("R8 below rx threshold", 32'(rx_req), 0);
    push_rx(32'h22220000);
    chk("R8 at rx threshold", 32'(rx_req), 1);

    rx_flush = 1; eng_rx_push = 1; eng_rx_data = 32'h33330000;
    @(negedge clk); rx_flush = 0; eng_rx_push = 0;
    chk("R10 rx flush over push", 32'(rx_count), 0);
    chk("R8 req after flush", 32'(rx_req), 0);

    tx_level = 7'd127;
    chk("R9 free 128 level 127", 32'(tx_req), 1);
    write_tx(32'hA0000000);
    chk("R9 free 127 level 127", 32'(tx_req), 1);
    write_tx(32'hB0000000);
    chk("R9 free 126 level 127", 32'(tx_req), 0);
    chk("R1 tx head order", eng_tx_data, 32'hA0000000);
    tx_flush = 1; bus_wr_en = 1; bus_wdata = 32'hC0000000;
    @(negedge clk); tx_flush = 0; bus_wr_en = 0;
    chk("R10 tx flush over write", 32'(tx_count), 0);
    chk("R9 req after tx flush", 32'(tx_req), 1);

    push_rx(32'h44440000);
    eng_rx_push = 1; eng_rx_data = 32'h55550000; bus_rd_en = 1;
    @(negedge clk); eng_rx_push = 0; bus_rd_en = 0;
    chk("R12 push+read count", 32'(rx_count), 1);
    chk("R12 push+read head", bus_rdata, 32'h55550000);

    finish_run();
  end
endmodule